// File: doc/BRIEF.md
# Load-Multiple Increment-After Sequencer

This block carries out a load of up to eight registers from consecutive memory words, followed by an update of the base register. A caller presents a base address, an 8-bit register selection mask and the index of the register that holds the base. The block then walks the mask from bit 0 upward. For each set bit it issues a single word read, waits for the data and writes the word into the register file.

When the walk is over, the base register receives the base plus four times the number of selected registers. If the base register is itself in the mask, this update is skipped, so the base register keeps the word it loaded. An empty mask and a misaligned base are both reported as faults when alignment checking is on. In either case no memory access takes place.

The memory side has only one request in flight. The address is held steady until read-valid comes back, so it can sit in front of memory of any latency. The register file port is a plain write strobe with an index and data.

Top module: `lm_sequencer`

## Requirements
- R1: Bit i of `regList` selects register i (i = 0..7). Exactly one read is issued per set bit. The words are written to `rfWrIdx` in ascending register order, each with the data returned for that read.
- R2: The first read address is `baseAddr` with bits [1:0] forced to zero. Each later read address is the previous one plus 4. `memAddr[1:0]` is always 0 while `memReq` is high.
- R3: The last read address equals the aligned base + 4 × (number of set bits) − 4.
- R4: When the base register is not in the mask, one extra register write follows the last load: index `baseReg`, data `baseAddr` + 4 × (number of set bits).
- R5: When the base register is in the mask, no extra write occurs. The last value written to the base register is the word loaded for it.
- R6: An all-zero mask raises `emptyFault` together with `done`, one cycle after the start is taken. It issues no read and no register write.
- R7: With `alignCheck` = 1 and `baseAddr[1:0]` ≠ 0, `alignFault` is raised with `done`, and no read or write occurs. With `alignCheck` = 0, the low two address bits are ignored and the load runs normally.
- R8: At most one read is outstanding. `memReq` stays high with a stable `memAddr` until `memRdValid` is seen.
- R9: `done` is a single-cycle pulse, asserted in the cycle after the final register write.
- R10: `startValid` is ignored while `busy` is high. An operation in progress is not disturbed by a new start.
- R11: After reset the block is idle. `busy`, `memReq`, `rfWrEn`, `done` and both fault flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start request, taken when idle |
| baseAddr | input | ADDR_W | Base address of the transfer |
| regList | input | NREG | Register selection mask, bit i selects register i |
| baseReg | input | RIDX_W | Index of the base register |
| alignCheck | input | 1 | Enables the misaligned-base fault |
| busy | output | 1 | Operation in progress |
| memReq | output | 1 | Read request, held until read-valid |
| memAddr | output | ADDR_W | Word-aligned read address |
| memRdValid | input | 1 | Read data valid, completes the pending request |
| memRdData | input | DATA_W | Read data |
| rfWrEn | output | 1 | Register file write strobe |
| rfWrIdx | output | RIDX_W | Register file write index |
| rfWrData | output | DATA_W | Register file write data |
| done | output | 1 | One-cycle completion pulse |
| emptyFault | output | 1 | Empty mask reported, valid with done |
| alignFault | output | 1 | Misaligned base reported, valid with done |

## Verification
The start is captured on one rising edge. The first `memReq` is visible right after that edge, and a fault `done` is visible at the same point instead. A load's register write appears combinationally in the same cycle that `memRdValid` is accepted. The base writeback follows one cycle after the last accepted read, and `done` comes one cycle after the last write. The bench drives `memRdValid` and its data on the falling edge, with a per-vector latency of zero to three cycles. It samples one time unit later and records the cycle number of every write and of `done`. This lets it compare the write order, the addresses and the done-to-last-write distance against values computed from the mask.

// File: rtl/lm_seq_pkg.sv
package lm_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_WRBACK,
    ST_FINISH
  } lmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch start operands
    logic advance;   // accepted read: retire lowest pending bit
    logic writeBack; // drive base update onto the register port
  } lmStrobes_t;

endpackage

// File: rtl/lm_seq_ctrl.sv
module lm_seq_ctrl
  import lm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       startFault,
  input  logic       lastBit,
  input  logic       baseInList,
  input  logic       memRdValid,
  output lmStrobes_t strb,
  output logic       memReq,
  output logic       busy,
  output logic       done
);

  lmState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strb           = '0;
    memReq         = 1'b0;
    done           = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          strb.capture = 1'b1;
          stateNext    = startFault ? ST_FINISH : ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        memReq = 1'b1;
        if (memRdValid) begin
          strb.advance = 1'b1;
          if (lastBit) stateNext = baseInList ? ST_FINISH : ST_WRBACK;
        end
      end
      ST_WRBACK: begin
        strb.writeBack = 1'b1;
        stateNext      = ST_FINISH;
      end
      ST_FINISH: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/lm_seq_dpath.sv
module lm_seq_dpath
  import lm_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int RIDX_W = $clog2(NREG),
  localparam int CNT_W  = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lmStrobes_t        strb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [NREG-1:0]   regList,
  input  logic [RIDX_W-1:0] baseReg,
  input  logic              alignCheck,
  input  logic [DATA_W-1:0] memRdData,
  output logic              startFault,
  output logic              lastBit,
  output logic              baseInList,
  output logic [ADDR_W-1:0] memAddr,
  output logic [RIDX_W-1:0] rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              emptyFlag,
  output logic              alignFlag
);

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] wbValue;
  logic [NREG-1:0]   pending;
  logic [RIDX_W-1:0] baseIdx;
  logic [CNT_W-1:0]  selCount;
  logic [RIDX_W-1:0] curIdx;
  logic [NREG-1:0]   lowBit;
  logic              listEmpty;
  logic              misaligned;

  // number of selected registers in the incoming mask
  always_comb begin
    selCount = '0;
    for (int i = 0; i < NREG; i++) selCount = selCount + CNT_W'(regList[i]);
  end

  // lowest pending register index
  always_comb begin
    curIdx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pending[i]) curIdx = RIDX_W'(i);
    end
  end

  assign lowBit     = pending & (~pending + NREG'(1));
  assign lastBit    = ((pending & (pending - NREG'(1))) == '0);
  assign listEmpty  = (regList == '0);
  assign misaligned = alignCheck && (baseAddr[1:0] != 2'b00);
  assign startFault = listEmpty || misaligned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg    <= '0;
      wbValue    <= '0;
      pending    <= '0;
      baseIdx    <= '0;
      baseInList <= 1'b0;
      emptyFlag  <= 1'b0;
      alignFlag  <= 1'b0;
    end else if (strb.capture) begin
      addrReg    <= baseAddr;
      wbValue    <= baseAddr + (ADDR_W'(selCount) << 2);
      pending    <= regList;
      baseIdx    <= baseReg;
      baseInList <= regList[baseReg];
      emptyFlag  <= listEmpty;
      alignFlag  <= misaligned;
    end else if (strb.advance) begin
      addrReg <= addrReg + ADDR_W'(4);
      pending <= pending & ~lowBit;
    end
  end

  assign memAddr  = {addrReg[ADDR_W-1:2], 2'b00};
  assign rfWrIdx  = strb.writeBack ? baseIdx : curIdx;
  assign rfWrData = strb.writeBack ? DATA_W'(wbValue) : memRdData;

endmodule

// File: rtl/lm_sequencer.sv
module lm_sequencer
  import lm_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [NREG-1:0]   regList,
  input  logic [RIDX_W-1:0] baseReg,
  input  logic              alignCheck,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rfWrEn,
  output logic [RIDX_W-1:0] rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              done,
  output logic              emptyFault,
  output logic              alignFault
);

  lmStrobes_t strb;
  logic startFault, lastBit, baseInList, emptyFlag, alignFlag;

  lm_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startFault (startFault),
    .lastBit    (lastBit),
    .baseInList (baseInList),
    .memRdValid (memRdValid),
    .strb       (strb),
    .memReq     (memReq),
    .busy       (busy),
    .done       (done)
  );

  lm_seq_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NREG   (NREG)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .baseAddr   (baseAddr),
    .regList    (regList),
    .baseReg    (baseReg),
    .alignCheck (alignCheck),
    .memRdData  (memRdData),
    .startFault (startFault),
    .lastBit    (lastBit),
    .baseInList (baseInList),
    .memAddr    (memAddr),
    .rfWrIdx    (rfWrIdx),
    .rfWrData   (rfWrData),
    .emptyFlag  (emptyFlag),
    .alignFlag  (alignFlag)
  );

  assign rfWrEn     = strb.advance | strb.writeBack;
  assign emptyFault = done & emptyFlag;
  assign alignFault = done & alignFlag;

endmodule

// File: rtl/lm_seq_chk.sv
module lm_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              rfWrEn,
  input logic              done,
  input logic              emptyFault,
  input logic              alignFault
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdValid) |=> (memReq && $stable(memAddr)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memRdValid) |=> (!memReq || memAddr == $past(memAddr) + STEP));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFault || alignFault) |-> done);

  // R7
  fault_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFault || alignFault) |-> !$past(busy));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !rfWrEn && !done));

endmodule

bind lm_sequencer lm_seq_chk #(.ADDR_W(ADDR_W)) u_lm_seq_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .rfWrEn     (rfWrEn),
  .done       (done),
  .emptyFault (emptyFault),
  .alignFault (alignFault)
);

// File: tb/test_lm_sequencer.sv
module test_lm_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [7:0]  regList = '0;
  logic [2:0]  baseReg = '0;
  logic        alignCheck = 1'b0;
  logic        busy, memReq, rfWrEn, done, emptyFault, alignFault;
  logic [31:0] memAddr, rfWrData;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic [2:0]  rfWrIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lm_sequencer i_lm_sequencer (
    .clk(clk), .rstN(rstN), .startValid(startValid), .baseAddr(baseAddr),
    .regList(regList), .baseReg(baseReg), .alignCheck(alignCheck), .busy(busy),
    .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .done(done), .emptyFault(emptyFault),
    .alignFault(alignFault)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {base, list, baseReg, alignCheck, latency}
  localparam logic [45:0] VEC [6] = '{
    {32'h0000_1000, 8'h01, 3'd1, 1'b1, 2'd0},  // single load + writeback (R1,R4)
    {32'h0000_2000, 8'hA5, 3'd6, 1'b1, 2'd1},  // sparse mask (R1,R2,R4)
    {32'h0000_3000, 8'hFF, 3'd3, 1'b1, 2'd0},  // full mask, base in list (R5)
    {32'h0000_4002, 8'h12, 3'd0, 1'b0, 2'd2},  // low bits ignored, no check (R7)
    {32'h0000_8000, 8'h80, 3'd7, 1'b1, 2'd3},  // top register is base (R5)
    {32'hFFFF_FFF8, 8'h0C, 3'd2, 1'b1, 2'd1}   // top of address space (R3)
  };

  task automatic runOp(input logic [31:0] base, input logic [7:0] list,
                       input logic [2:0] breg, input bit chk, input int lat,
                       input bit poke);
    logic [2:0]  expIdx [9];
    logic [31:0] expData [9];
    logic [31:0] expAddr [8];
    logic [31:0] alignedBase, lastAddr;
    int nSel, nWr, nRd, wrCnt, rdCnt, doneCnt, lastWr, doneAt, waitCnt, reqSeen;
    bit faultE, emptyE, alignE, sawEmpty, sawAlign;
    alignedBase = {base[31:2], 2'b00};
    nSel = 0;
    for (int i = 0; i < 8; i++) begin
      if (list[i]) begin
        expAddr[nSel] = alignedBase + 32'(4 * nSel);
        expIdx[nSel]  = 3'(i);
        expData[nSel] = memWord(expAddr[nSel]);
        nSel++;
      end
    end
    emptyE = (list == 8'h00);
    alignE = chk && (base[1:0] != 2'b00);
    faultE = emptyE || alignE;
    nWr = nSel;
    if (!list[breg]) begin
      expIdx[nWr]  = breg;
      expData[nWr] = base + 32'(4 * nSel);
      nWr++;
    end
    if (faultE) nWr = 0;
    nRd = faultE ? 0 : nSel;

    baseAddr = base; regList = list; baseReg = breg; alignCheck = chk;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    wrCnt = 0; rdCnt = 0; doneCnt = 0; lastWr = -1; doneAt = -1;
    waitCnt = 0; reqSeen = 0; lastAddr = '0; sawEmpty = 0; sawAlign = 0;
    for (int cyc = 0; cyc < 200 && doneCnt == 0; cyc++) begin
      if (poke && cyc == 1) begin
        startValid = 1'b1; regList = 8'hFF; baseAddr = 32'h0000_0000; baseReg = 3'd5;
      end else begin
        startValid = 1'b0;
      end
      if (memReq) begin
        if (waitCnt == lat) begin
          memRdValid = 1'b1; memRdData = memWord(memAddr); waitCnt = 0;
        end else begin
          memRdValid = 1'b0; waitCnt++;
        end
      end else begin
        memRdValid = 1'b0;
      end
      #1;
      if (memReq) reqSeen++;
      if (memReq && memRdValid) begin
        if (rdCnt < nRd)
          check(memAddr == expAddr[rdCnt], "R2", "read address", memAddr, expAddr[rdCnt]);
        else
          check(1'b0, "R1", "extra read", 32'(rdCnt), 32'(nRd));
        lastAddr = memAddr;
        rdCnt++;
      end
      if (rfWrEn) begin
        if (wrCnt < nWr) begin
          string rq;
          rq = (wrCnt >= nSel) ? "R4" : ((expIdx[wrCnt] == breg) ? "R5" : "R1");
          check(rfWrIdx == expIdx[wrCnt], rq, "write index", 32'(rfWrIdx), 32'(expIdx[wrCnt]));
          check(rfWrData == expData[wrCnt], rq, "write data", rfWrData, expData[wrCnt]);
        end else begin
          check(1'b0, "R5", "unexpected write", 32'(rfWrIdx), 32'(nWr));
        end
        wrCnt++;
        lastWr = cyc;
      end
      if (done) begin
        doneCnt++; doneAt = cyc; sawEmpty = emptyFault; sawAlign = alignFault;
      end
      @(negedge clk);
    end
    memRdValid = 1'b0;
    #1;
    check(wrCnt == nWr, poke ? "R10" : "R1", "write count", 32'(wrCnt), 32'(nWr));
    check(rdCnt == nRd, "R1", "read count", 32'(rdCnt), 32'(nRd));
    check(doneCnt == 1, "R9", "done seen", 32'(doneCnt), 32'd1);
    check(done == 1'b0 && busy == 1'b0, "R9", "done after pulse", {30'd0, done, busy}, 32'd0);
    if (nWr > 0)
      check(doneAt == lastWr + 1, "R9", "done cycle", 32'(doneAt), 32'(lastWr + 1));
    if (nRd > 0)
      check(lastAddr == alignedBase + 32'(4 * nSel) - 32'd4, "R3", "final address",
            lastAddr, alignedBase + 32'(4 * nSel) - 32'd4);
    check(sawEmpty == emptyE, "R6", "empty flag", 32'(sawEmpty), 32'(emptyE));
    check(sawAlign == alignE, "R7", "align flag", 32'(sawAlign), 32'(alignE));
    if (faultE) check(reqSeen == 0, "R6", "no request on fault", 32'(reqSeen), 32'd0);
    if (faultE) check(doneAt == 0, "R7", "fault done timing", 32'(doneAt), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    #1;
    check({busy, memReq, rfWrEn, done, emptyFault, alignFault} == 6'b0, "R11",
          "outputs in reset", 32'({busy, memReq, rfWrEn, done, emptyFault, alignFault}), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check({busy, memReq, rfWrEn, done} == 4'b0, "R11", "idle after reset",
          32'({busy, memReq, rfWrEn, done}), 32'd0);
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      runOp(VEC[v][45:14], VEC[v][13:6], VEC[v][5:3], VEC[v][2], int'(VEC[v][1:0]), 1'b0);
      @(negedge clk);
    end

    // R6: empty mask
    runOp(32'h0000_6000, 8'h00, 3'd2, 1'b1, 0, 1'b0);
    @(negedge clk);
    // R7: misaligned base with checking on
    runOp(32'h0000_5001, 8'h0F, 3'd4, 1'b1, 0, 1'b0);
    @(negedge clk);
    // R10: second start during an operation is ignored
    runOp(32'h0000_7000, 8'h41, 3'd3, 1'b1, 2, 1'b1);
    @(negedge clk);
    // R5: base is the lowest selected register
    runOp(32'h0000_9000, 8'h07, 3'd0, 1'b1, 1, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule